// File: doc/BRIEF.md
# Washer Drum Rotation Phase Sequencer

This block turns a washer drum through a repeating rotation pattern for as long as a wash is in progress. Each pattern is 60 seconds long and made of four timed phases: the drum turns forward, stands still, turns in reverse, and stands still again. A prescaler divides the 1 kHz system clock down to a one-second tick. For the phase in progress, the block shows how many seconds have passed as a two-digit BCD value that counts upward, and it lights exactly one of three indicators: forward, reverse, or stopped.

A control state machine with three states sets when the phases advance. `ST_IDLE` waits for a start. `ST_RUN` advances the phases. `ST_HOLD` freezes all timing. The named transitions are:

- **GO** (`ST_IDLE`→`ST_RUN`): start key low while `run_en` is high.
- **FREEZE** (`ST_RUN`→`ST_HOLD`): pause key low.
- **RESUME** (`ST_HOLD`→`ST_RUN`): start key low.
- **ABORT** (`ST_RUN` or `ST_HOLD`→`ST_IDLE`): `run_en` low. ABORT also puts the pattern back to the start of the forward phase.

The rotation phases are `PH_FWD`, `PH_DWELL_A`, `PH_REV` and `PH_DWELL_B`. They advance in that order and wrap back to `PH_FWD`.

A wash timer outside this block drives `run_en`. A display driver outside this block takes the BCD digits.

Top module: `wash_rotation_seq`

## Requirements
- R1: In `ST_RUN` the phases follow this fixed order and then repeat: forward for FWD_SEC (20) seconds, dwell for DWELL_SEC (10) seconds, reverse for REV_SEC (20) seconds, dwell for DWELL_SEC (10) seconds. One full pattern is 60 seconds.
- R2: A one-second tick is produced after every TICK_DIV clock cycles spent in `ST_RUN`. After GO, the first second is shown exactly TICK_DIV cycles after the edge that samples the start key.
- R3: The phase seconds count up from 0. They are output as BCD, with the tens digit on `secs_tens` and the units digit on `secs_units` (units always 0 to 9). The count returns to 0 on the tick that moves to the next phase.
- R4: Exactly one indicator is high at all times. `ind_fwd` is high only in `ST_RUN` during `PH_FWD`. `ind_rev` is high only in `ST_RUN` during `PH_REV`. `ind_hold` is high in every other case: dwell phases, `ST_HOLD` and `ST_IDLE`.
- R5: After reset the block is in `ST_IDLE` at the start of `PH_FWD`, with the count at 00, the prescaler cleared, and `ind_hold` high.
- R6: In `ST_IDLE` nothing advances until the start key is sampled low while `run_en` is high. A start press while `run_en` is low is ignored.
- R7: When the pause key is sampled low in `ST_RUN`, the block enters `ST_HOLD`. In `ST_HOLD` the phase, the count and the prescaler remain frozen. A start press then resumes timing from exactly the point where it stopped. Neither the edge that samples pause nor the edge that samples start counts as a running cycle.
- R8: When `run_en` is sampled low in `ST_RUN` or `ST_HOLD`, the block enters `ST_IDLE` with the phase at `PH_FWD`, the count at 00 and the prescaler cleared. The next run begins at forward 00 and starts a full second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 1 kHz in the application |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | High while the wash timer allows rotation |
| start_n | input | 1 | Start/resume key, active low |
| pause_n | input | 1 | Pause key, active low |
| ind_fwd | output | 1 | Forward rotation indicator |
| ind_rev | output | 1 | Reverse rotation indicator |
| ind_hold | output | 1 | Stopped indicator |
| secs_tens | output | 4 | BCD tens digit of the seconds in the current phase |
| secs_units | output | 4 | BCD units digit of the seconds in the current phase |

## Verification
The bench builds the block with TICK_DIV = 4 and leaves the phase lengths at 20, 10 and 20 seconds. With that setting one full 60-second pattern takes only 240 running cycles. The bench can therefore compare every second of a complete pattern, its wrap back to forward, and the exact cycle of the first tick. It also places a pause in the middle of a second, so the test shows that the prescaler keeps its partial count across `ST_HOLD`.

// File: rtl/wash_seq_pkg.sv
`timescale 1ns/1ps
package wash_seq_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } mode_e;

    // Numeric order is the rotation order; increment wraps the pattern.
    typedef enum logic [1:0] {
        PH_FWD     = 2'd0,
        PH_DWELL_A = 2'd1,
        PH_REV     = 2'd2,
        PH_DWELL_B = 2'd3
    } phase_e;

    function automatic logic [7:0] last_sec_bcd(input int unsigned len);
        int unsigned v;
        v = len - 1;
        return {4'(v / 10), 4'(v % 10)};
    endfunction

endpackage

// File: rtl/wash_tick_gen.sv
`timescale 1ns/1ps
module wash_tick_gen #(
    parameter int unsigned DIV = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic enable,
    output logic tick
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    assign tick = enable && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (enable) begin
            cnt_q <= tick ? '0 : cnt_q + 1'b1;
        end
    end

    assert_prescale_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    assert_prescale_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear) |=> $stable(cnt_q));

endmodule

// File: rtl/wash_phase_timer.sv
`timescale 1ns/1ps
module wash_phase_timer
    import wash_seq_pkg::*;
#(
    parameter int unsigned FWD_SEC   = 20,
    parameter int unsigned DWELL_SEC = 10,
    parameter int unsigned REV_SEC   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       tick,
    output phase_e     phase,
    output logic [3:0] tens,
    output logic [3:0] units
);
    localparam logic [7:0] FWD_LAST   = last_sec_bcd(FWD_SEC);
    localparam logic [7:0] DWELL_LAST = last_sec_bcd(DWELL_SEC);
    localparam logic [7:0] REV_LAST   = last_sec_bcd(REV_SEC);

    phase_e     phase_q;
    logic [3:0] tens_q, units_q;
    logic [7:0] last_code;
    logic       at_end;

    always_comb begin
        unique case (phase_q)
            PH_FWD:  last_code = FWD_LAST;
            PH_REV:  last_code = REV_LAST;
            default: last_code = DWELL_LAST;
        endcase
    end

    assign at_end = ({tens_q, units_q} == last_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_FWD;
            tens_q  <= 4'd0;
            units_q <= 4'd0;
        end else if (clear) begin
            phase_q <= PH_FWD;
            tens_q  <= 4'd0;
            units_q <= 4'd0;
        end else if (tick) begin
            if (at_end) begin
                phase_q <= phase_e'(phase_q + 2'd1);
                tens_q  <= 4'd0;
                units_q <= 4'd0;
            end else if (units_q == 4'd9) begin
                units_q <= 4'd0;
                tens_q  <= tens_q + 4'd1;
            end else begin
                units_q <= units_q + 4'd1;
            end
        end
    end

    assign phase = phase_q;
    assign tens  = tens_q;
    assign units = units_q;

    assert_bcd_units_R3: assert property (@(posedge clk) disable iff (!rst_n)
        units_q <= 4'd9);

    assert_phase_starts_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != $past(phase_q)) |-> ({tens_q, units_q} == 8'h00));

    assert_count_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clear) |=> ($stable({tens_q, units_q}) && $stable(phase_q)));

endmodule

// File: rtl/wash_rotation_seq.sv
`timescale 1ns/1ps
module wash_rotation_seq
    import wash_seq_pkg::*;
#(
    parameter int unsigned TICK_DIV  = 1000,
    parameter int unsigned FWD_SEC   = 20,
    parameter int unsigned DWELL_SEC = 10,
    parameter int unsigned REV_SEC   = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic       start_n,
    input  logic       pause_n,
    output logic       ind_fwd,
    output logic       ind_rev,
    output logic       ind_hold,
    output logic [3:0] secs_tens,
    output logic [3:0] secs_units
);
    mode_e  mode_q, mode_d;
    phase_e phase;
    logic   advance, restart, tick;

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            ST_IDLE: if (run_en && !start_n) mode_d = ST_RUN;     // GO
            ST_RUN:  if (!run_en)            mode_d = ST_IDLE;    // ABORT
                     else if (!pause_n)      mode_d = ST_HOLD;    // FREEZE
            ST_HOLD: if (!run_en)            mode_d = ST_IDLE;    // ABORT
                     else if (!start_n)      mode_d = ST_RUN;     // RESUME
            default:                         mode_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= ST_IDLE;
        else        mode_q <= mode_d;
    end

    assign advance = (mode_q == ST_RUN) && run_en && pause_n;
    assign restart = (mode_q != ST_IDLE) && !run_en;

    wash_tick_gen #(.DIV(TICK_DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart),
        .enable (advance),
        .tick   (tick)
    );

    wash_phase_timer #(
        .FWD_SEC   (FWD_SEC),
        .DWELL_SEC (DWELL_SEC),
        .REV_SEC   (REV_SEC)
    ) timer_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart),
        .tick  (tick),
        .phase (phase),
        .tens  (secs_tens),
        .units (secs_units)
    );

    always_comb begin
        ind_fwd  = 1'b0;
        ind_rev  = 1'b0;
        ind_hold = 1'b1;
        if (mode_q == ST_RUN) begin
            unique case (phase)
                PH_FWD:  begin ind_fwd = 1'b1; ind_hold = 1'b0; end
                PH_REV:  begin ind_rev = 1'b1; ind_hold = 1'b0; end
                default: ind_hold = 1'b1;
            endcase
        end
    end

    assert_one_indicator_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ind_fwd, ind_rev, ind_hold}) == 1);

    assert_abort_rewinds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (ind_hold && secs_tens == 4'd0 && secs_units == 4'd0));

    assert_idle_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == ST_IDLE && (start_n || !run_en)) |=> (ind_hold && $stable({secs_tens, secs_units})));

endmodule

// File: tb/wash_rotation_seq_tb.sv
`timescale 1ns/1ps
module wash_rotation_seq_tb_top;
    localparam int unsigned DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0, run_en = 1'b0, start_n = 1'b1, pause_n = 1'b1;
    logic ind_fwd, ind_rev, ind_hold;
    logic [3:0] secs_tens, secs_units;

    int checks = 0, failures = 0;
    int rc = 0;          // running cycles counted by the bench model
    bit running = 0;
    bit done = 0;

    always #2 clk = ~clk;

    wash_rotation_seq #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .start_n(start_n),
        .pause_n(pause_n), .ind_fwd(ind_fwd), .ind_rev(ind_rev),
        .ind_hold(ind_hold), .secs_tens(secs_tens), .secs_units(secs_units)
    );

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            if (running) rc++;
        end
        @(negedge clk);
    endtask

    task automatic press_start();
        start_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        start_n = 1'b1;
    endtask

    task automatic press_pause();
        pause_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        pause_n = 1'b1;
    endtask

    task automatic check(input string req);
        int s, p;
        logic ef, er, eh;
        p = (rc / DIV) % 60;
        ef = 0; er = 0; eh = 1;
        if (p < 20)      begin s = p;      ef = running; end
        else if (p < 30) begin s = p - 20; end
        else if (p < 50) begin s = p - 30; er = running; end
        else             begin s = p - 50; end
        eh = !(ef || er);
        checks++;
        if (ind_fwd !== ef || ind_rev !== er || ind_hold !== eh ||
            secs_tens !== 4'(s / 10) || secs_units !== 4'(s % 10)) begin
            failures++;
            $display("FAIL %s: got fwd=%b rev=%b hold=%b secs=%0d%0d expected fwd=%b rev=%b hold=%b secs=%0d%0d",
                     req, ind_fwd, ind_rev, ind_hold, secs_tens, secs_units,
                     ef, er, eh, s / 10, s % 10);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        step(3);
        rst_n = 1'b1;
        running = 0; rc = 0;
        check("R5 reset state");
    endtask

    task automatic t_idle_wait();
        run_en = 1'b1;
        step(12);
        check("R6 idle without start");
        run_en = 1'b0;
        press_start();
        run_en = 1'b1;
        step(5);
        check("R6 start ignored while run_en low");
    endtask

    task automatic t_first_tick();
        press_start();
        running = 1;
        check("R2 forward at 00 after start");
        step(DIV - 1);
        check("R2 no second before TICK_DIV cycles");
        step(1);
        check("R2 first second at TICK_DIV cycles");
    endtask

    task automatic t_full_cycle();
        for (int i = 0; i < 62; i++) begin
            step(DIV);
            check("R1 R3 R4 phase pattern");
        end
    endtask

    task automatic t_pause();
        // move into the middle of a second inside the reverse phase
        while (((rc / DIV) % 60) != 37) step(1);
        step(2);
        running = 0;
        press_pause();
        check("R7 paused indicator");
        step(5 * DIV);
        check("R7 frozen while held");
        press_start();
        running = 1;
        check("R7 resumed from same point");
        step(DIV - 2);
        check("R7 partial second kept");
        step(14 * DIV);
        check("R7 continues into dwell");
    endtask

    task automatic t_abort();
        step(7);
        run_en = 1'b0;
        step(1);
        running = 0; rc = 0;
        check("R8 abort from run");
        run_en = 1'b1;
        step(6);
        check("R8 stays idle after abort");
        press_start();
        running = 1;
        step(DIV - 1);
        check("R8 restart full second");
        step(1);
        check("R8 restart first tick");
        step(3 * DIV);
        running = 0;
        press_pause();
        run_en = 1'b0;
        step(1);
        rc = 0;
        check("R8 abort from hold");
        run_en = 1'b1;
        press_start();
        running = 1;
        step(DIV * 21);
        check("R8 run after abort from hold");
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_idle_wait();
        t_first_tick();
        t_full_cycle();
        t_pause();
        t_abort();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got no completion expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule